// File: doc/BRIEF.md
# Escaped Byte-Stream Packet Extractor

This block sits between a byte-wide serial receiver and a DMA engine that accepts AXI4-Stream. Each received byte arrives as a one-cycle valid strobe with eight data bits. The incoming stream carries packets bounded by two reserved marker values, one that opens a packet and one that closes it. A third reserved value, the escape, makes the byte after it ordinary content: that byte is restored by XOR with 0x20, so content bytes may equal any of the three marker values.

The extractor removes the markers and escapes. It holds back one content byte until the next byte shows whether that content byte ends the packet. It then writes beats into a 16-entry queue whose head drives an AXI4-Stream master. TLAST marks the final content byte, so the downstream engine finishes one transfer per packet and the processor is interrupted once per packet, not once per byte. Two error signals are provided: a one-cycle pulse for a malformed packet end, and a sticky flag for content lost because the queue was full.

Top module: `byte_deframer_axis`

## Requirements
- R1: While the active-low reset is asserted, the output stream has TVALID low, both error outputs are low and the queue is empty. After release the block waits for an opening byte.
- R2: Outside a packet, every byte other than the opening value 0x7E is discarded and produces no output. 0x7E opens a packet.
- R3: Inside a packet, content bytes leave in arrival order. An escape byte 0x7D produces no beat, and the byte after it is delivered XOR 0x20 whatever its value.
- R4: The closing value 0x7F sets TLAST on the last content byte of the packet, and no other byte of that packet has TLAST set.
- R5: An opening byte 0x7E seen inside a packet, even directly after an escape, abandons the partial packet. A content byte still held back is emitted with TLAST set, no error is raised, and a new packet begins.
- R6: A packet that closes with no content, or with an escape directly before 0x7F, makes frame_err high for exactly one cycle. The dangling escape yields no beat, an empty packet yields no beat, and a held-back byte before the dangling escape is emitted with TLAST set.
- R7: A byte can be accepted on every clock cycle, with no gaps needed between bytes.
- R8: The queue holds 16 beats. A beat that arrives while 16 beats are stored is dropped and sets overflow, which stays set until overflow_clear is high at a clock edge. A drop in the same cycle takes priority over the clear.
- R9: While TVALID is high and TREADY is low, TVALID stays high and TDATA and TLAST stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| rx_valid | input | 1 | Received byte strobe, one cycle per byte |
| rx_byte | input | 8 | Received byte value |
| m_axis_tvalid | output | 1 | Output beat valid |
| m_axis_tready | input | 1 | Downstream ready |
| m_axis_tdata | output | 8 | Output content byte |
| m_axis_tlast | output | 1 | Last content byte of a packet |
| frame_err | output | 1 | One-cycle pulse on a malformed packet end |
| overflow | output | 1 | Sticky flag: a beat was dropped because the queue was full |
| overflow_clear | input | 1 | Clears overflow |

## Verification
The bench uses the default marker values 0x7E, 0x7F and 0x7D and the default queue depth of 16. With a depth this small, one 20-byte packet sent against a stalled consumer is enough to fill the queue, drop beats and raise the overflow flag. The same run then drains the queue with TREADY toggling, which exercises the hold rule and the clearing of the sticky flag. The default markers make escaped copies of all three control values easy to send and to predict.

// File: rtl/bdf_pkg.sv
package bdf_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_ESC  = 2'd2
  } dfr_state_e;

  typedef struct packed {
    logic              last;
    logic [BYTE_W-1:0] data;
  } beat_t;

endpackage

// File: rtl/bdf_unframe.sv
module bdf_unframe
  import bdf_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SOF_BYTE = 8'h7E,
  parameter logic [BYTE_W-1:0] EOF_BYTE = 8'h7F,
  parameter logic [BYTE_W-1:0] ESC_BYTE = 8'h7D,
  parameter logic [BYTE_W-1:0] ESC_MASK = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              wr_en,
  output beat_t             wr_beat,
  output logic              frame_err
);

  dfr_state_e        state_q, state_d;
  logic              hold_vld_q, hold_vld_d;
  logic [BYTE_W-1:0] hold_data_q, hold_data_d;
  logic              err_q, err_d;

  logic is_sof, is_eof, is_esc;
  assign is_sof = (in_data == SOF_BYTE);
  assign is_eof = (in_data == EOF_BYTE);
  assign is_esc = (in_data == ESC_BYTE);

  always_comb begin
    state_d      = state_q;
    hold_vld_d   = hold_vld_q;
    hold_data_d  = hold_data_q;
    err_d        = 1'b0;
    wr_en        = 1'b0;
    wr_beat.last = 1'b0;
    wr_beat.data = hold_data_q;
    if (in_valid) begin
      unique case (state_q)
        ST_IDLE: begin
          if (is_sof) begin
            state_d    = ST_BODY;
            hold_vld_d = 1'b0;
          end
        end
        ST_BODY: begin
          if (is_sof) begin
            wr_en        = hold_vld_q;
            wr_beat.last = 1'b1;
            hold_vld_d   = 1'b0;
          end else if (is_eof) begin
            wr_en        = hold_vld_q;
            wr_beat.last = 1'b1;
            err_d        = ~hold_vld_q;
            hold_vld_d   = 1'b0;
            state_d      = ST_IDLE;
          end else if (is_esc) begin
            state_d = ST_ESC;
          end else begin
            wr_en       = hold_vld_q;
            hold_data_d = in_data;
            hold_vld_d  = 1'b1;
          end
        end
        ST_ESC: begin
          if (is_sof) begin
            wr_en        = hold_vld_q;
            wr_beat.last = 1'b1;
            hold_vld_d   = 1'b0;
            state_d      = ST_BODY;
          end else if (is_eof) begin
            wr_en        = hold_vld_q;
            wr_beat.last = 1'b1;
            err_d        = 1'b1;
            hold_vld_d   = 1'b0;
            state_d      = ST_IDLE;
          end else begin
            wr_en       = hold_vld_q;
            hold_data_d = in_data ^ ESC_MASK;
            hold_vld_d  = 1'b1;
            state_d     = ST_BODY;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      hold_vld_q  <= 1'b0;
      hold_data_q <= '0;
    end else if (in_valid) begin
      state_q     <= state_d;
      hold_vld_q  <= hold_vld_d;
      hold_data_q <= hold_data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign frame_err = err_q;

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !wr_en);

  assert_esc_no_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BODY && in_valid && is_esc) |=> (state_q == ST_ESC));

endmodule

// File: rtl/bdf_fifo.sv
module bdf_fifo
  import bdf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  beat_t wr_beat,
  output logic  drop,
  output logic  rd_valid,
  input  logic  rd_ready,
  output beat_t rd_beat
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  beat_t         mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, push, pop;

  assign full     = (cnt_q == FULL_CNT);
  assign rd_valid = (cnt_q != '0);
  assign push     = wr_en & ~full;
  assign pop      = rd_valid & rd_ready;
  assign drop     = wr_en & full;
  assign rd_beat  = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
    if (pop)  rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wr_ptr_q == AW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem[gi] <= '0;
      else if (slot_en) mem[gi] <= wr_beat;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !pop) |=> full);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_beat)));

endmodule

// File: rtl/bdf_sticky.sv
module bdf_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

  assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);

endmodule

// File: rtl/byte_deframer_axis.sv
module byte_deframer_axis
  import bdf_pkg::*;
#(
  parameter logic [7:0] SOF_BYTE   = 8'h7E,
  parameter logic [7:0] EOF_BYTE   = 8'h7F,
  parameter logic [7:0] ESC_BYTE   = 8'h7D,
  parameter logic [7:0] ESC_MASK   = 8'h20,
  parameter int         FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       m_axis_tvalid,
  input  logic       m_axis_tready,
  output logic [7:0] m_axis_tdata,
  output logic       m_axis_tlast,
  output logic       frame_err,
  output logic       overflow,
  input  logic       overflow_clear
);

  logic  wr_en, drop;
  beat_t wr_beat, rd_beat;

  bdf_unframe #(
    .SOF_BYTE(SOF_BYTE),
    .EOF_BYTE(EOF_BYTE),
    .ESC_BYTE(ESC_BYTE),
    .ESC_MASK(ESC_MASK)
  ) u_unframe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_valid),
    .in_data  (rx_byte),
    .wr_en    (wr_en),
    .wr_beat  (wr_beat),
    .frame_err(frame_err)
  );

  bdf_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_beat (wr_beat),
    .drop    (drop),
    .rd_valid(m_axis_tvalid),
    .rd_ready(m_axis_tready),
    .rd_beat (rd_beat)
  );

  bdf_sticky u_ovf (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (drop),
    .clr_i (overflow_clear),
    .flag_o(overflow)
  );

  assign m_axis_tdata = rd_beat.data;
  assign m_axis_tlast = rd_beat.last;

  assert_axis_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_axis_tvalid && !m_axis_tready) |=>
      (m_axis_tvalid && $stable(m_axis_tdata) && $stable(m_axis_tlast)));

endmodule

// File: tb/byte_deframer_axis_tb.sv
module byte_deframer_axis_tb;

  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       tvalid, tready, tlast, ferr, ovf, ovf_clr;
  logic [7:0] tdata;

  always #2.5 clk = ~clk;

  byte_deframer_axis u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .m_axis_tvalid(tvalid), .m_axis_tready(tready), .m_axis_tdata(tdata),
    .m_axis_tlast(tlast), .frame_err(ferr), .overflow(ovf),
    .overflow_clear(ovf_clr)
  );

  int checks = 0;
  int fails  = 0;
  int beats  = 0;
  int lasts  = 0;
  int errs   = 0;
  bit done   = 0;

  // Behavioural reference: mode 0 outside, 1 inside, 2 after escape.
  logic [8:0] q[$];
  int         m_mode;
  bit         m_hold_v;
  logic [7:0] m_hold;
  bit         m_err, m_ovf;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_mode = 0; m_hold_v = 0; m_hold = 0; m_err = 0; m_ovf = 0;
    end else begin
      bit w, wl, e, pop, dropped;
      logic [7:0] wd;
      w = 0; wl = 0; e = 0; wd = m_hold;
      if (rx_valid) begin
        if (m_mode == 0) begin
          if (rx_byte == 8'h7E) begin m_mode = 1; m_hold_v = 0; end
        end else if (rx_byte == 8'h7E) begin
          w = m_hold_v; wl = 1; m_hold_v = 0; m_mode = 1;
        end else if (rx_byte == 8'h7F) begin
          w = m_hold_v; wl = 1; e = (m_mode == 2) || !m_hold_v;
          m_hold_v = 0; m_mode = 0;
        end else if (m_mode == 1 && rx_byte == 8'h7D) begin
          m_mode = 2;
        end else begin
          w = m_hold_v;
          m_hold = (m_mode == 2) ? (rx_byte ^ 8'h20) : rx_byte;
          m_hold_v = 1; m_mode = 1;
        end
      end
      pop = (q.size() != 0) && tready;
      dropped = w && (q.size() == DEPTH);
      if (pop) begin
        beats++;
        if (q[0][8]) lasts++;
        void'(q.pop_front());
      end
      if (w && !dropped) q.push_back({wl, wd});
      if (dropped) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      m_err = e;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9 tvalid", tvalid, q.size() != 0);
      if (q.size() != 0) begin
        check("R3 tdata", tdata, q[0][7:0]);
        check("R4 tlast", tlast, q[0][8]);
      end
      check("R6 frame_err", ferr, m_err);
      check("R8 overflow", ovf, m_ovf);
      if (ferr) errs++;
    end
  end

  task automatic send(logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int b0, l0, e0;
    rst_n = 1'b0; rx_valid = 0; rx_byte = 0; tready = 1; ovf_clr = 0;
    idle(3);
    check("R1 tvalid in reset", tvalid, 0);
    check("R1 frame_err in reset", ferr, 0);
    check("R1 overflow in reset", ovf, 0);
    rst_n = 1'b1;
    idle(2);

    // R2: bytes outside a packet
    send(8'h11); send(8'h7F); send(8'h7D); send(8'h22);
    idle(3);
    check("R2 no output outside packet", beats, 0);
    check("R2 tvalid low", tvalid, 0);

    // R7/R4: back-to-back packet
    b0 = beats; l0 = lasts;
    send(8'h7E); send(8'h01); send(8'h02); send(8'h03); send(8'h7F);
    idle(4);
    check("R7 back-to-back beats", beats - b0, 3);
    check("R4 one tlast", lasts - l0, 1);

    // R3: escaped control values
    b0 = beats;
    send(8'h7E); send(8'h7D); send(8'h5E); send(8'h7D); send(8'h5D);
    send(8'h7D); send(8'h5F); send(8'h41); send(8'h7F);
    idle(4);
    check("R3 escaped beats", beats - b0, 4);

    // R6: empty packet
    b0 = beats; e0 = errs;
    send(8'h7E); send(8'h7F);
    idle(3);
    check("R6 empty packet no beat", beats - b0, 0);
    check("R6 empty packet error", errs - e0, 1);

    // R6: escape before close
    b0 = beats; l0 = lasts; e0 = errs;
    send(8'h7E); send(8'h05); send(8'h7D); send(8'h7F);
    idle(3);
    check("R6 dangling escape beats", beats - b0, 1);
    check("R6 dangling escape tlast", lasts - l0, 1);
    check("R6 dangling escape error", errs - e0, 1);

    // R5: abort by reopening
    b0 = beats; l0 = lasts; e0 = errs;
    send(8'h7E); send(8'h0A); send(8'h0B); send(8'h7E); send(8'h0C); send(8'h7F);
    idle(3);
    check("R5 abort beats", beats - b0, 3);
    check("R5 abort tlasts", lasts - l0, 2);
    check("R5 abort no error", errs - e0, 0);

    // R8/R9: overflow with stalled consumer
    b0 = beats;
    tready = 0;
    send(8'h7E);
    for (int i = 0; i < 20; i++) send(8'(8'h30 + i));
    send(8'h7F);
    idle(2);
    check("R8 overflow set", ovf, 1);
    check("R9 tvalid held", tvalid, 1);
    for (int i = 0; i < 60; i++) begin
      tready = (i % 3) != 0;
      @(negedge clk);
    end
    tready = 1;
    idle(2);
    check("R8 stored beats drained", beats - b0, DEPTH);
    check("R8 overflow sticky", ovf, 1);
    ovf_clr = 1; idle(1); ovf_clr = 0;
    idle(1);
    check("R8 overflow cleared", ovf, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule